// File: doc/BRIEF.md
# CAN Message-Object Store with Debug and Direct-Access Word Views

This block holds the message objects of a CAN controller and lets a 32-bit host bus reach them through two word-line views. Each object carries a 29-bit identifier, a 29-bit mask, direction and extended-format bits for both the identifier and the mask, six control flags, a data length code, eight data bytes and a 5-bit parity field. The controller's normal path reads and writes whole objects through a separate interface port.

In the debug view, used while the controller is suspended, the host can read each object as six words. In the direct-access view, it can read and write each object as five words. The direct-access view opens only while test mode and the direct-access request are both asserted. It also has to be entered while the init bit is high. While either view is open, the block raises a lockout that blocks the normal interface path. Each view has its own bit packing, and reserved positions read as zero. A host read returns its data one cycle later, with a valid strobe.

Top module: `canram_port`

## Requirements
- R1: With no view open (lockout low), host writes change no object and host reads return zero.
- R2: `lockout` is high whenever `dbgSuspend` is high or the direct-access view is open. It is low whenever both `testMode` and `dbgSuspend` are low.
- R3: The direct-access view opens one cycle after `testMode`, `rdaReq` and `initBit` are all high. Without `initBit` a request is refused. Once open, the view stays open while `testMode` and `rdaReq` stay high, even if `initBit` drops.
- R4: Reserved bit positions read as zero in both views, and writing them has no effect.
- R5: A transfer covers one word. The object index is the word address divided by the view's words per object (5 in direct access, 6 in debug), and the remainder selects the word. Addresses past the last object read zero, and writes to them change nothing.
- R6: The direct-access word layout is as follows:
  - word 0 = {byte4, byte5, byte6, byte7} (most significant first);
  - word 1 = {byte0, byte1, byte2, byte3};
  - word 2 = {ID[27:0], DLC};
  - word 3 = {Msk[28:0], Xtd, Dir, ID[28]};
  - word 4 = {20'b0, parity[3:0], MsgLst, UMask, TxIE, RxIE, RmtEn, EOB, MXtd, MDir}.
- R7: The debug word layout is as follows:
  - word 0 = parity in bits 4:0;
  - word 1 = {MXtd, MDir, 0, Msk};
  - word 2 = {0, Xtd, Dir, ID};
  - word 3 = MsgLst at bit 14, UMask at 12, TxIE at 11, RxIE at 10, RmtEn at 9, EOB at 7 and DLC in 3:0;
  - word 4 = {byte3, byte2, byte1, byte0};
  - word 5 = {byte7, byte6, byte5, byte4}.
- R8: Host writes through the debug view are ignored.
- R9: `busRvalid` is high exactly one cycle after each host read request, whether or not the read is allowed.
- R10: When lockout is low, an interface write replaces the whole object, and an interface read returns it one cycle later with `ifRvalid`. When lockout is high, interface writes are ignored and interface reads return zero.
- R11: If the direct-access view is open while `dbgSuspend` is high, host accesses use the direct-access layout.
- R12: A direct-access write of word 4 updates only parity bits 3:0. Parity bit 4 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; clears all objects |
| testMode | input | 1 | Test mode enable |
| rdaReq | input | 1 | Direct-access view request |
| initBit | input | 1 | Controller init state |
| dbgSuspend | input | 1 | Debug/suspend view active |
| lockout | output | 1 | Blocks the interface path |
| busSel | input | 1 | Host transfer request |
| busWrite | input | 1 | Host transfer is a write |
| busAddr | input | ADDR_W | Host word address |
| busWdata | input | 32 | Host write data |
| busRdata | output | 32 | Host read data |
| busRvalid | output | 1 | Host read data valid |
| ifSel | input | 1 | Interface transfer request |
| ifWrite | input | 1 | Interface transfer is a write |
| ifIdx | input | IDX_W | Interface object index |
| ifWobj | input | OBJ_W | Interface write object |
| ifRobj | output | OBJ_W | Interface read object |
| ifRvalid | output | 1 | Interface read valid |

## Verification
The assertions assume that the mode inputs change only between clock edges and that host and interface requests last a single cycle each. They also assume that `dbgSuspend` is never raised and dropped in the same cycle as a read whose data they check. The stimulus follows these rules: it changes modes only on idle cycles, pulses each request for one cycle at the falling edge, and waits a full cycle after every mode change before it checks `lockout` or issues a transfer.

// File: rtl/canram_pkg.sv
package canram_pkg;

  localparam int DA_WPO  = 5;
  localparam int DBG_WPO = 6;

  typedef struct packed {
    logic [4:0]      parity;
    logic [7:0][7:0] data;
    logic [3:0]      dlc;
    logic            msgLst;
    logic            uMask;
    logic            txIe;
    logic            rxIe;
    logic            rmtEn;
    logic            eob;
    logic            mxtd;
    logic            mdir;
    logic            xtd;
    logic            dir;
    logic [28:0]     msk;
    logic [28:0]     id;
  } msgObj_t;

  localparam int OBJ_W = $bits(msgObj_t);

  typedef struct packed {
    logic       rdReq;
    logic       rdEn;
    logic       wrEn;
    logic       daView;
    logic [2:0] wordSel;
    logic       ifRdReq;
    logic       ifRdEn;
    logic       ifWrEn;
  } portStb_t;

  function automatic logic [31:0] packDa(msgObj_t o, logic [2:0] w);
    logic [31:0] r;
    case (w)
      3'd0:    r = {o.data[4], o.data[5], o.data[6], o.data[7]};
      3'd1:    r = {o.data[0], o.data[1], o.data[2], o.data[3]};
      3'd2:    r = {o.id[27:0], o.dlc};
      3'd3:    r = {o.msk, o.xtd, o.dir, o.id[28]};
      3'd4:    r = {20'd0, o.parity[3:0], o.msgLst, o.uMask, o.txIe, o.rxIe,
                    o.rmtEn, o.eob, o.mxtd, o.mdir};
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic msgObj_t unpackDa(msgObj_t o, logic [2:0] w, logic [31:0] d);
    msgObj_t r;
    r = o;
    case (w)
      3'd0: {r.data[4], r.data[5], r.data[6], r.data[7]} = d;
      3'd1: {r.data[0], r.data[1], r.data[2], r.data[3]} = d;
      3'd2: {r.id[27:0], r.dlc} = d;
      3'd3: {r.msk, r.xtd, r.dir, r.id[28]} = d;
      3'd4: begin
        r.parity[3:0] = d[11:8];
        {r.msgLst, r.uMask, r.txIe, r.rxIe, r.rmtEn, r.eob, r.mxtd, r.mdir} = d[7:0];
      end
      default: r = o;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] packDbg(msgObj_t o, logic [2:0] w);
    logic [31:0] r;
    case (w)
      3'd0:    r = {27'd0, o.parity};
      3'd1:    r = {o.mxtd, o.mdir, 1'b0, o.msk};
      3'd2:    r = {1'b0, o.xtd, o.dir, o.id};
      3'd3:    r = {16'd0, 1'b0, o.msgLst, 1'b0, o.uMask, o.txIe, o.rxIe,
                    o.rmtEn, 1'b0, o.eob, 3'd0, o.dlc};
      3'd4:    r = {o.data[3], o.data[2], o.data[1], o.data[0]};
      3'd5:    r = {o.data[7], o.data[6], o.data[5], o.data[4]};
      default: r = 32'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/canram_ctrl.sv
module canram_ctrl
  import canram_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              rdaReq,
  input  logic              initBit,
  input  logic              dbgSuspend,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ifSel,
  input  logic              ifWrite,
  input  logic [IDX_W-1:0]  ifIdx,
  output portStb_t          stb,
  output logic [IDX_W-1:0]  objIdx,
  output logic              lockout
);

  logic        rdaArmed;
  logic        daOpen;
  logic        viewOn;
  logic [31:0] addrExt;
  logic [31:0] qDa;
  logic [31:0] qDbg;
  logic [31:0] quot;
  logic [2:0]  remDa;
  logic [2:0]  remDbg;
  logic        inRange;
  logic        ifInRange;

  always_ff @(posedge clk) begin
    if (!rstN) rdaArmed <= 1'b0;
    else       rdaArmed <= testMode & rdaReq & (rdaArmed | initBit);
  end

  assign daOpen  = testMode & rdaReq & rdaArmed;
  assign viewOn  = daOpen | dbgSuspend;
  assign lockout = viewOn;

  always_comb begin
    addrExt   = 32'(busAddr);
    qDa       = addrExt / 32'(DA_WPO);
    qDbg      = addrExt / 32'(DBG_WPO);
    remDa     = 3'(addrExt - qDa * 32'(DA_WPO));
    remDbg    = 3'(addrExt - qDbg * 32'(DBG_WPO));
    quot      = daOpen ? qDa : qDbg;
    inRange   = quot < 32'(NUM_OBJ);
    ifInRange = 32'(ifIdx) < 32'(NUM_OBJ);
    objIdx    = quot[IDX_W-1:0];

    stb.rdReq   = busSel & ~busWrite;
    stb.rdEn    = busSel & ~busWrite & viewOn & inRange;
    stb.wrEn    = busSel & busWrite & daOpen & inRange;
    stb.daView  = daOpen;
    stb.wordSel = daOpen ? remDa : remDbg;
    stb.ifRdReq = ifSel & ~ifWrite;
    stb.ifRdEn  = ifSel & ~ifWrite & ~viewOn & ifInRange;
    stb.ifWrEn  = ifSel & ifWrite & ~viewOn & ifInRange;
  end

endmodule

// File: rtl/canram_dp.sv
module canram_dp
  import canram_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStb_t         stb,
  input  logic [IDX_W-1:0] objIdx,
  input  logic [IDX_W-1:0] ifIdx,
  input  logic [31:0]      busWdata,
  input  logic [OBJ_W-1:0] ifWobj,
  output logic [31:0]      busRdata,
  output logic             busRvalid,
  output logic [OBJ_W-1:0] ifRobj,
  output logic             ifRvalid
);

  msgObj_t     objMem [NUM_OBJ];
  msgObj_t     selObj;
  logic [31:0] rdWord;

  always_comb begin
    selObj = objMem[objIdx];
    rdWord = stb.daView ? packDa(selObj, stb.wordSel) : packDbg(selObj, stb.wordSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_OBJ; i++) objMem[i] <= '0;
    end else if (stb.wrEn) begin
      objMem[objIdx] <= unpackDa(selObj, stb.wordSel, busWdata);
    end else if (stb.ifWrEn) begin
      objMem[ifIdx] <= msgObj_t'(ifWobj);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
      ifRvalid  <= 1'b0;
      ifRobj    <= '0;
    end else begin
      busRvalid <= stb.rdReq;
      busRdata  <= stb.rdEn ? rdWord : 32'd0;
      ifRvalid  <= stb.ifRdReq;
      ifRobj    <= stb.ifRdEn ? OBJ_W'(objMem[ifIdx]) : '0;
    end
  end

endmodule

// File: rtl/canram_port.sv
module canram_port
  import canram_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              rdaReq,
  input  logic              initBit,
  input  logic              dbgSuspend,
  output logic              lockout,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  input  logic              ifSel,
  input  logic              ifWrite,
  input  logic [IDX_W-1:0]  ifIdx,
  input  logic [OBJ_W-1:0]  ifWobj,
  output logic [OBJ_W-1:0]  ifRobj,
  output logic              ifRvalid
);

  portStb_t         stb;
  logic [IDX_W-1:0] objIdx;

  canram_ctrl #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .rdaReq(rdaReq),
    .initBit(initBit), .dbgSuspend(dbgSuspend), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .ifSel(ifSel), .ifWrite(ifWrite),
    .ifIdx(ifIdx), .stb(stb), .objIdx(objIdx), .lockout(lockout)
  );

  canram_dp #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .objIdx(objIdx), .ifIdx(ifIdx),
    .busWdata(busWdata), .ifWobj(ifWobj), .busRdata(busRdata),
    .busRvalid(busRvalid), .ifRobj(ifRobj), .ifRvalid(ifRvalid)
  );

endmodule

// File: rtl/canram_chk.sv
module canram_chk
  import canram_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             testMode,
  input logic             initBit,
  input logic             dbgSuspend,
  input logic             lockout,
  input logic             busSel,
  input logic             busWrite,
  input logic [31:0]      busRdata,
  input logic             busRvalid,
  input logic             ifSel,
  input logic             ifWrite,
  input logic [OBJ_W-1:0] ifRobj,
  input logic             ifRvalid
);

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite) |=> busRvalid);

  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |=> !busRvalid);

  assert_closed_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !lockout) |=> (busRdata == 32'd0));

  assert_lockout_dbg_R2: assert property (@(posedge clk) disable iff (!rstN)
    dbgSuspend |-> lockout);

  assert_lockout_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !dbgSuspend) |-> !lockout);

  assert_entry_refused_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!lockout && !initBit) |=> (lockout == dbgSuspend));

  assert_if_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ifSel && !ifWrite && lockout) |=> (ifRobj == '0));

  assert_if_rvalid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ifSel && !ifWrite) |=> ifRvalid);

endmodule

bind canram_port canram_chk uChk (
  .clk(clk), .rstN(rstN), .testMode(testMode), .initBit(initBit),
  .dbgSuspend(dbgSuspend), .lockout(lockout), .busSel(busSel),
  .busWrite(busWrite), .busRdata(busRdata), .busRvalid(busRvalid),
  .ifSel(ifSel), .ifWrite(ifWrite), .ifRobj(ifRobj), .ifRvalid(ifRvalid)
);

// File: tb/sim_canram_port.sv
module sim_canram_port;
  import canram_pkg::*;

  localparam int NOBJ = 4;
  localparam int AW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0, rdaReq = 1'b0, initBit = 1'b0, dbgSuspend = 1'b0;
  logic lockout;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busRvalid;
  logic ifSel = 1'b0, ifWrite = 1'b0;
  logic [1:0] ifIdx = '0;
  logic [OBJ_W-1:0] ifWobj = '0;
  logic [OBJ_W-1:0] ifRobj;
  logic ifRvalid;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  canram_port #(.NUM_OBJ(NOBJ), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .testMode(testMode), .rdaReq(rdaReq),
    .initBit(initBit), .dbgSuspend(dbgSuspend), .lockout(lockout),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .ifSel(ifSel), .ifWrite(ifWrite), .ifIdx(ifIdx), .ifWobj(ifWobj),
    .ifRobj(ifRobj), .ifRvalid(ifRvalid)
  );

  // Expected words, built from the layouts in the requirements.
  function automatic logic [31:0] expDa(msgObj_t o, int w);
    logic [31:0] v = '0;
    if (w == 0) v = {o.data[4], o.data[5], o.data[6], o.data[7]};
    if (w == 1) v = {o.data[0], o.data[1], o.data[2], o.data[3]};
    if (w == 2) begin v[31:4] = o.id[27:0]; v[3:0] = o.dlc; end
    if (w == 3) begin v[31:3] = o.msk; v[2] = o.xtd; v[1] = o.dir; v[0] = o.id[28]; end
    if (w == 4) begin
      v[11:8] = o.parity[3:0];
      v[7] = o.msgLst; v[6] = o.uMask; v[5] = o.txIe; v[4] = o.rxIe;
      v[3] = o.rmtEn;  v[2] = o.eob;   v[1] = o.mxtd; v[0] = o.mdir;
    end
    return v;
  endfunction

  function automatic logic [31:0] expDbg(msgObj_t o, int w);
    logic [31:0] v = '0;
    if (w == 0) v[4:0] = o.parity;
    if (w == 1) begin v[31] = o.mxtd; v[30] = o.mdir; v[28:0] = o.msk; end
    if (w == 2) begin v[30] = o.xtd; v[29] = o.dir; v[28:0] = o.id; end
    if (w == 3) begin
      v[14] = o.msgLst; v[12] = o.uMask; v[11] = o.txIe; v[10] = o.rxIe;
      v[9] = o.rmtEn; v[7] = o.eob; v[3:0] = o.dlc;
    end
    if (w == 4) v = {o.data[3], o.data[2], o.data[1], o.data[0]};
    if (w == 5) v = {o.data[7], o.data[6], o.data[5], o.data[4]};
    return v;
  endfunction

  // Monitor: pops the scoreboard on every read response.
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R9 unexpected read response actual=%h expected=none", busRdata);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (busRdata !== e) begin
          testsFailed++;
          $display("FAIL %s actual=%h expected=%h", t, busRdata, e);
        end
      end
    end
  end

  task automatic busRead(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = AW'(a);
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic busWr(input int a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = AW'(a); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic ifWr(input int idx, input msgObj_t o);
    @(negedge clk);
    ifSel = 1'b1; ifWrite = 1'b1; ifIdx = 2'(idx); ifWobj = o;
    @(negedge clk);
    ifSel = 1'b0; ifWrite = 1'b0;
  endtask

  task automatic ifRd(input int idx, input msgObj_t e, input string t);
    @(negedge clk);
    ifSel = 1'b1; ifWrite = 1'b0; ifIdx = 2'(idx);
    @(negedge clk);
    ifSel = 1'b0;
    testsRun++;
    if (ifRvalid !== 1'b1 || msgObj_t'(ifRobj) !== e) begin
      testsFailed++;
      $display("FAIL %s valid=%b actual=%h expected=%h", t, ifRvalid, ifRobj, e);
    end
  endtask

  task automatic setMode(input logic tm, input logic rq, input logic ib, input logic ds);
    @(negedge clk);
    testMode = tm; rdaReq = rq; initBit = ib; dbgSuspend = ds;
    @(negedge clk);
  endtask

  task automatic chkLock(input logic e, input string t);
    testsRun++;
    if (lockout !== e) begin
      testsFailed++;
      $display("FAIL %s lockout actual=%b expected=%b", t, lockout, e);
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    msgObj_t objA, objB, objZ;
    objZ = '0;
    objA = '0;
    objA.id = 29'h12345678; objA.msk = 29'h0F0F0F0F;
    objA.xtd = 1'b1; objA.mdir = 1'b1; objA.msgLst = 1'b1; objA.txIe = 1'b1;
    objA.rmtEn = 1'b1; objA.eob = 1'b1; objA.dlc = 4'd8; objA.parity = 5'h15;
    for (int i = 0; i < 8; i++) objA.data[i] = 8'h10 + 8'(i);
    objB = '0;
    objB.id = 29'h0ABC0123; objB.msk = 29'h1FFF0000; objB.dir = 1'b1;
    objB.mxtd = 1'b1; objB.uMask = 1'b1; objB.rxIe = 1'b1; objB.dlc = 4'd3;
    objB.parity = 5'h1A;
    for (int i = 0; i < 8; i++) objB.data[i] = 8'hA0 + 8'(i);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chkLock(1'b0, "R2 reset");
    ifRd(0, objZ, "R10 reset object");

    ifWr(1, objA);
    ifWr(2, objB);
    ifRd(1, objA, "R10 interface read back");

    busRead(5, 32'd0, "R1 read with no view open");
    busWr(5, 32'hDEADBEEF);

    setMode(1'b1, 1'b1, 1'b0, 1'b0);
    chkLock(1'b0, "R3 entry refused without init");
    busRead(5, 32'd0, "R3 refused view reads zero");

    setMode(1'b1, 1'b1, 1'b1, 1'b0);
    chkLock(1'b1, "R2 lockout in direct access");
    ifRd(1, objZ, "R10 interface read blocked");
    ifWr(1, objB);
    for (int w = 0; w < 5; w++) busRead(5 + w, expDa(objA, w), "R6 direct-access word obj1");

    busWr(5, 32'hCAFEBABE);
    objA.data[4] = 8'hCA; objA.data[5] = 8'hFE; objA.data[6] = 8'hBA; objA.data[7] = 8'hBE;
    busRead(5, 32'hCAFEBABE, "R6 direct-access write word0");

    busWr(13, 32'hFFFFFFFF);
    busWr(14, 32'hFFFFFFFF);
    objB.msk = 29'h1FFFFFFF; objB.xtd = 1'b1; objB.dir = 1'b1; objB.id[28] = 1'b1;
    objB.parity[3:0] = 4'hF;
    {objB.msgLst, objB.uMask, objB.txIe, objB.rxIe, objB.rmtEn, objB.eob, objB.mxtd, objB.mdir} = 8'hFF;
    busRead(13, 32'hFFFFFFFF, "R6 direct-access word3 write");
    busRead(14, 32'h00000FFF, "R4 reserved bits of word4 read zero");

    busWr(20, 32'hFFFFFFFF);
    busRead(20, 32'd0, "R5 out-of-range read");
    busRead(0, 32'd0, "R5 out-of-range write had no effect");

    setMode(1'b1, 1'b1, 1'b0, 1'b1);
    chkLock(1'b1, "R3 view held after init drops");
    busRead(5, expDa(objA, 0), "R11 direct-access layout wins");

    setMode(1'b0, 1'b0, 1'b0, 1'b1);
    chkLock(1'b1, "R2 lockout in debug view");
    for (int w = 0; w < 6; w++) busRead(6 + w, expDbg(objA, w), "R7 debug word obj1");
    busRead(11, 32'hBEBAFECA, "R7 debug byte order word5");
    busWr(6, 32'hFFFFFFFF);
    busRead(6, expDbg(objA, 0), "R8 debug write ignored");
    busRead(12, 32'h0000001F, "R12 parity bit4 kept");
    busRead(15, expDbg(objB, 3), "R4 debug reserved bits zero");
    busRead(24, 32'd0, "R5 debug out-of-range");

    setMode(1'b0, 1'b0, 1'b0, 1'b0);
    chkLock(1'b0, "R2 lockout clear");
    ifRd(1, objA, "R1 R10 blocked writes had no effect");
    ifRd(2, objB, "R10 full object after direct writes");

    repeat (4) @(negedge clk);
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL R9 missing responses actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule